// File: doc/BRIEF.md
# Per-Element Job Table with Overrun Ripple Adjustment

This block is the job queue of one packet processing element. A scheduler appends jobs at the tail. Each job carries a planned start time, an estimated finish time, a buffer address, a flow id and a sequence number. The element takes jobs from the head. When the element finishes a job, it reports completion together with the actual finish time. The head entry is then retired.

If the reported finish time reaches or passes the planned start of the next queued job, that job and the jobs queued behind it are pushed later in time. The shift moves down the queue one entry per clock. It stops at the first entry whose start already lies beyond the updated finish time of the entry before it, or after the tail entry. While the shift is in progress the table is busy and refuses writes.

The finish time of the tail entry is presented continuously, so that a scheduler can compare several elements and choose the one that becomes free earliest.

The controller has two states:
- IDLE accepts writes and completions.
- RIPPLE adjusts one entry per cycle.

The transitions are:
- IDLE→RIPPLE: a completion is accepted while more than one entry is stored.
- RIPPLE→IDLE: the examined entry needs no shift, or it is the tail.
- RIPPLE→RIPPLE: the entry was shifted and it is not the tail.

Top module: `job_table`

## Requirements
- R1: After reset the table is empty: `empty`=1, `full`=0, `busy`=0, `err`=0, `count`=0, `tail_finish`=0, `head_valid`=0.
- R2: In IDLE, a write with `done_en` low and the table not full appends an entry at the tail. `count` rises by one, and `tail_finish` shows the finish time of the most recently written entry. The head outputs show the oldest entry.
- R3: When `count` equals DEPTH, `full`=1. A write is then refused, the stored entries are unchanged, and `err` is 1 in the following cycle.
- R4: In IDLE with the table not empty, `done_en` retires the head entry and `count` falls by one. With the table empty, `done_en` changes nothing.
- R5: If the reported actual finish time is below the start time of the entry that becomes the new head, no entry is changed.
- R6: If the reported actual finish time is greater than or equal to the new head's start time S, that entry's start and finish both increase by (actual − S + 1). For example, actual = S gives a shift of 1.
- R7: After an entry is shifted, the next entry (start S', following the stored next-entry link) is shifted by (new finish − S' + 1) when new finish ≥ S'. The ripple stops at the first entry where new finish < S', or after the tail entry is adjusted. One entry is examined per cycle.
- R8: A completion that leaves at least one entry sets `busy` from the next cycle. `busy` stays high for one cycle per examined entry. While `busy` is high, writes are refused with `err`, and completions are ignored.
- R9: A write presented in the same cycle as `done_en` is refused and raises `err`. The completion takes priority.
- R10: `err` is a registered flag that is high for exactly the one cycle after each refused write, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Append request |
| wr_start | input | TW | Planned start time of the new job |
| wr_finish | input | TW | Estimated finish time of the new job |
| wr_addr | input | AW | Buffer address of the new job |
| wr_flow | input | FW | Flow id of the new job |
| wr_seq | input | SW | Sequence number of the new job |
| done_en | input | 1 | Completion report for the head job |
| done_time | input | TW | Actual finish time of the completed job |
| head_valid | output | 1 | Head outputs hold a job |
| head_start | output | TW | Start time of the head job |
| head_finish | output | TW | Finish time of the head job |
| head_addr | output | AW | Buffer address of the head job |
| head_flow | output | FW | Flow id of the head job |
| head_seq | output | SW | Sequence number of the head job |
| tail_finish | output | TW | Finish time of the tail job, 0 when empty |
| count | output | $clog2(DEPTH+1) | Number of stored jobs |
| full | output | 1 | Table holds DEPTH jobs |
| empty | output | 1 | Table holds no jobs |
| busy | output | 1 | Ripple adjustment in progress |
| err | output | 1 | Previous cycle's write was refused |

## Verification
A wrong shift amount or a wrong link shows at the head outputs one cycle after the ripple reaches the head entry. For entries behind the head, it shows only once the entries ahead of them have been retired. The bench therefore retires every shifted queue entry by entry. A ripple that stops too early or runs too long shows as a `busy` pulse of the wrong length, and as a wrong `tail_finish` in the cycle after it ends. A refused write that slips in shows as a `count` and `tail_finish` mismatch one cycle later.

// File: rtl/job_table_pkg.sv
package job_table_pkg;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RIPPLE = 1'b1
    } jt_state_e;

endpackage

// File: rtl/jt_store.sv
module jt_store #(
    parameter int DEPTH = 8,
    parameter int TW    = 16,
    parameter int AW    = 32,
    parameter int FW    = 8,
    parameter int SW    = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [IW-1:0] wlink,
    input  logic [TW-1:0] wstart,
    input  logic [TW-1:0] wfinish,
    input  logic [AW-1:0] waddr,
    input  logic [FW-1:0] wflow,
    input  logic [SW-1:0] wseq,
    input  logic          adj_en,
    input  logic [IW-1:0] adj_idx,
    input  logic [TW-1:0] adj_amt,
    input  logic [IW-1:0] head_idx,
    input  logic [IW-1:0] cur_idx,
    input  logic [IW-1:0] tail_idx,
    output logic [TW-1:0] head_start,
    output logic [TW-1:0] head_finish,
    output logic [AW-1:0] head_addr,
    output logic [FW-1:0] head_flow,
    output logic [SW-1:0] head_seq,
    output logic [TW-1:0] cur_start,
    output logic [TW-1:0] cur_finish,
    output logic [IW-1:0] cur_link,
    output logic [TW-1:0] tail_finish
);

    logic [TW-1:0] start_q  [DEPTH];
    logic [TW-1:0] finish_q [DEPTH];
    logic [AW-1:0] addr_q   [DEPTH];
    logic [FW-1:0] flow_q   [DEPTH];
    logic [SW-1:0] seq_q    [DEPTH];
    logic [IW-1:0] link_q   [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                start_q[g]  <= '0;
                finish_q[g] <= '0;
                addr_q[g]   <= '0;
                flow_q[g]   <= '0;
                seq_q[g]    <= '0;
                link_q[g]   <= '0;
            end else if (we && (widx == IW'(g))) begin
                start_q[g]  <= wstart;
                finish_q[g] <= wfinish;
                addr_q[g]   <= waddr;
                flow_q[g]   <= wflow;
                seq_q[g]    <= wseq;
                link_q[g]   <= wlink;
            end else if (adj_en && (adj_idx == IW'(g))) begin
                start_q[g]  <= start_q[g] + adj_amt;
                finish_q[g] <= finish_q[g] + adj_amt;
            end
        end
    end

    always_comb begin
        head_start  = start_q[head_idx];
        head_finish = finish_q[head_idx];
        head_addr   = addr_q[head_idx];
        head_flow   = flow_q[head_idx];
        head_seq    = seq_q[head_idx];
        cur_start   = start_q[cur_idx];
        cur_finish  = finish_q[cur_idx];
        cur_link    = link_q[cur_idx];
        tail_finish = finish_q[tail_idx];
    end

endmodule

// File: rtl/jt_ctrl.sv
module jt_ctrl
    import job_table_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int TW    = 16,
    parameter int IW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          done_en,
    input  logic [TW-1:0] done_time,
    input  logic [TW-1:0] cur_start,
    input  logic [TW-1:0] cur_finish,
    input  logic [IW-1:0] cur_link,
    output logic          we,
    output logic [IW-1:0] widx,
    output logic [IW-1:0] wlink,
    output logic          adj_en,
    output logic [IW-1:0] adj_idx,
    output logic [TW-1:0] adj_amt,
    output logic [IW-1:0] head_idx,
    output logic [IW-1:0] cur_idx,
    output logic [IW-1:0] tail_idx,
    output logic [CW-1:0] count,
    output logic          busy,
    output logic          err
);

    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    jt_state_e     state_q, state_d;
    logic [IW-1:0] head_q, wptr_q, cur_q;
    logic [CW-1:0] count_q;
    logic [TW-1:0] ref_q;
    logic          err_q;

    logic          is_idle, is_empty, is_full;
    logic          take_done, take_wr, need_shift, at_tail;
    logic [IW-1:0] head_nx, wptr_nx;
    logic [TW-1:0] shift_amt;

    always_comb begin
        is_idle    = (state_q == ST_IDLE);
        is_empty   = (count_q == '0);
        is_full    = (count_q == FULL_CNT);
        take_done  = is_idle && done_en && !is_empty;
        take_wr    = is_idle && wr_en && !done_en && !is_full;
        head_nx    = (head_q == LAST) ? '0 : head_q + IW'(1);
        wptr_nx    = (wptr_q == LAST) ? '0 : wptr_q + IW'(1);
        tail_idx   = (wptr_q == '0) ? LAST : wptr_q - IW'(1);
        at_tail    = (cur_q == tail_idx);
        need_shift = (state_q == ST_RIPPLE) && (ref_q >= cur_start);
        shift_amt  = ref_q - cur_start + TW'(1);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_done && (count_q > CW'(1))) state_d = ST_RIPPLE;
            end
            ST_RIPPLE: begin
                if (!need_shift || at_tail) state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            wptr_q  <= '0;
            cur_q   <= '0;
            count_q <= '0;
            ref_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= wr_en && !take_wr;
            if (take_done) begin
                head_q  <= head_nx;
                cur_q   <= head_nx;
                ref_q   <= done_time;
                count_q <= count_q - CW'(1);
            end else if (take_wr) begin
                wptr_q  <= wptr_nx;
                count_q <= count_q + CW'(1);
            end
            if (need_shift) begin
                ref_q <= cur_finish + shift_amt;
                if (!at_tail) cur_q <= cur_link;
            end
        end
    end

    always_comb begin
        we       = take_wr;
        widx     = wptr_q;
        wlink    = wptr_nx;
        adj_en   = need_shift;
        adj_idx  = cur_q;
        adj_amt  = shift_amt;
        head_idx = head_q;
        cur_idx  = cur_q;
        count    = count_q;
        busy     = (state_q == ST_RIPPLE);
        err      = err_q;
    end

    // R3
    full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && is_full && wr_en && !done_en) |=> (err_q && count_q == FULL_CNT));

    // R8
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RIPPLE) && wr_en) |=> (err_q && count_q == $past(count_q)));

    // R4
    pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_done |=> (count_q == $past(count_q) - CW'(1)));

    // R4
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && is_empty && done_en) |=> (count_q == '0));

    // R7
    ripple_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RIPPLE) |-> (count_q != '0));

    // R7
    ripple_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (need_shift && !at_tail) |=> (state_q == ST_RIPPLE));

    // R9
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_idle && done_en && wr_en) |=> err_q);

endmodule

// File: rtl/job_table.sv
module job_table #(
    parameter int DEPTH = 8,
    parameter int TW    = 16,
    parameter int AW    = 32,
    parameter int FW    = 8,
    parameter int SW    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [TW-1:0] wr_start,
    input  logic [TW-1:0] wr_finish,
    input  logic [AW-1:0] wr_addr,
    input  logic [FW-1:0] wr_flow,
    input  logic [SW-1:0] wr_seq,
    input  logic          done_en,
    input  logic [TW-1:0] done_time,
    output logic          head_valid,
    output logic [TW-1:0] head_start,
    output logic [TW-1:0] head_finish,
    output logic [AW-1:0] head_addr,
    output logic [FW-1:0] head_flow,
    output logic [SW-1:0] head_seq,
    output logic [TW-1:0] tail_finish,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty,
    output logic          busy,
    output logic          err
);

    logic          we, adj_en;
    logic [IW-1:0] widx, wlink, adj_idx, head_idx, cur_idx, tail_idx, cur_link;
    logic [TW-1:0] adj_amt, cur_start, cur_finish, tail_fin_raw;
    logic [TW-1:0] h_start, h_finish;
    logic [AW-1:0] h_addr;
    logic [FW-1:0] h_flow;
    logic [SW-1:0] h_seq;

    jt_ctrl #(.DEPTH(DEPTH), .TW(TW), .IW(IW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .done_en(done_en),
        .done_time(done_time), .cur_start(cur_start), .cur_finish(cur_finish),
        .cur_link(cur_link), .we(we), .widx(widx), .wlink(wlink),
        .adj_en(adj_en), .adj_idx(adj_idx), .adj_amt(adj_amt),
        .head_idx(head_idx), .cur_idx(cur_idx), .tail_idx(tail_idx),
        .count(count), .busy(busy), .err(err)
    );

    jt_store #(.DEPTH(DEPTH), .TW(TW), .AW(AW), .FW(FW), .SW(SW), .IW(IW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wlink(wlink),
        .wstart(wr_start), .wfinish(wr_finish), .waddr(wr_addr),
        .wflow(wr_flow), .wseq(wr_seq), .adj_en(adj_en), .adj_idx(adj_idx),
        .adj_amt(adj_amt), .head_idx(head_idx), .cur_idx(cur_idx),
        .tail_idx(tail_idx), .head_start(h_start), .head_finish(h_finish),
        .head_addr(h_addr), .head_flow(h_flow), .head_seq(h_seq),
        .cur_start(cur_start), .cur_finish(cur_finish), .cur_link(cur_link),
        .tail_finish(tail_fin_raw)
    );

    always_comb begin
        empty       = (count == '0);
        full        = (count == CW'(DEPTH));
        head_valid  = !empty;
        head_start  = empty ? '0 : h_start;
        head_finish = empty ? '0 : h_finish;
        head_addr   = empty ? '0 : h_addr;
        head_flow   = empty ? '0 : h_flow;
        head_seq    = empty ? '0 : h_seq;
        tail_finish = empty ? '0 : tail_fin_raw;
    end

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        !rst_n |=> (empty && !busy && !err));

    // R10
    err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> !err);

endmodule

// File: tb/job_table_test.sv
module job_table_test;

    localparam int D  = 4;
    localparam int TW = 16;
    localparam int AW = 32;
    localparam int FW = 8;
    localparam int SW = 16;
    localparam int CW = $clog2(D + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [TW-1:0] wr_start = '0, wr_finish = '0, done_time = '0;
    logic [AW-1:0] wr_addr = '0;
    logic [FW-1:0] wr_flow = '0;
    logic [SW-1:0] wr_seq = '0;
    logic          done_en = 1'b0;
    logic          head_valid, full, empty, busy, err;
    logic [TW-1:0] head_start, head_finish, tail_finish;
    logic [AW-1:0] head_addr;
    logic [FW-1:0] head_flow;
    logic [SW-1:0] head_seq;
    logic [CW-1:0] count;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    job_table #(.DEPTH(D), .TW(TW), .AW(AW), .FW(FW), .SW(SW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_start(wr_start),
        .wr_finish(wr_finish), .wr_addr(wr_addr), .wr_flow(wr_flow),
        .wr_seq(wr_seq), .done_en(done_en), .done_time(done_time),
        .head_valid(head_valid), .head_start(head_start),
        .head_finish(head_finish), .head_addr(head_addr),
        .head_flow(head_flow), .head_seq(head_seq), .tail_finish(tail_finish),
        .count(count), .full(full), .empty(empty), .busy(busy), .err(err)
    );

    // behavioural reference model
    int  ms[$], mf[$], ma[$], mfl[$], msq[$];
    bit  mbusy, merr;
    int  mcur, mref;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms.delete(); mf.delete(); ma.delete(); mfl.delete(); msq.delete();
            mbusy = 0; merr = 0; mcur = 0; mref = 0;
        end else if (!mbusy) begin
            bit wr_ok;
            wr_ok = 0;
            if (done_en && ms.size() > 0) begin
                void'(ms.pop_front()); void'(mf.pop_front()); void'(ma.pop_front());
                void'(mfl.pop_front()); void'(msq.pop_front());
                if (ms.size() > 0) begin
                    mbusy = 1; mcur = 0; mref = int'(done_time);
                end
            end else if (wr_en && !done_en && ms.size() < D) begin
                ms.push_back(int'(wr_start)); mf.push_back(int'(wr_finish));
                ma.push_back(int'(wr_addr)); mfl.push_back(int'(wr_flow));
                msq.push_back(int'(wr_seq));
                wr_ok = 1;
            end
            merr = wr_en && !wr_ok;
        end else begin
            merr = wr_en;
            if (mref >= ms[mcur]) begin
                int amt;
                amt = mref - ms[mcur] + 1;
                ms[mcur] = ms[mcur] + amt;
                mf[mcur] = mf[mcur] + amt;
                mref = mf[mcur];
                if (mcur == ms.size() - 1) mbusy = 0;
                else mcur = mcur + 1;
            end else begin
                mbusy = 0;
            end
        end
    end

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2", "count", int'(count), ms.size());
            chk("R2", "empty", int'(empty), int'(ms.size() == 0));
            chk("R3", "full", int'(full), int'(ms.size() == D));
            chk("R8", "busy", int'(busy), int'(mbusy));
            chk("R10", "err", int'(err), int'(merr));
            chk("R2", "tail_finish", int'(tail_finish), (ms.size() > 0) ? mf[$] : 0);
            if (ms.size() > 0) begin
                chk("R7", "head_start", int'(head_start), ms[0]);
                chk("R7", "head_finish", int'(head_finish), mf[0]);
                chk("R2", "head_addr", int'(head_addr), ma[0]);
                chk("R2", "head_flow", int'(head_flow), mfl[0]);
                chk("R2", "head_seq", int'(head_seq), msq[0]);
            end
        end
    end

    task automatic push(input int s, input int f, input int a, input int fl, input int sq);
        wr_en = 1; wr_start = TW'(s); wr_finish = TW'(f);
        wr_addr = AW'(a); wr_flow = FW'(fl); wr_seq = SW'(sq);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic finish_job(input int t);
        done_en = 1; done_time = TW'(t);
        @(negedge clk);
        done_en = 0;
    endtask

    task automatic settle();
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "empty", int'(empty), 1);
        chk("R1", "full", int'(full), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "err", int'(err), 0);
        chk("R1", "tail_finish", int'(tail_finish), 0);
        chk("R1", "head_valid", int'(head_valid), 0);

        // R2 fill, R3 overflow refused
        push(10, 20, 100, 1, 1);
        push(21, 30, 101, 2, 2);
        push(31, 40, 102, 1, 3);
        push(60, 70, 103, 3, 4);
        chk("R3", "full", int'(full), 1);
        chk("R2", "tail_finish", int'(tail_finish), 70);
        push(99, 120, 104, 4, 5);
        chk("R3", "err after full write", int'(err), 1);
        chk("R3", "tail unchanged", int'(tail_finish), 70);

        // R6/R7 overrun ripple stopped by slack, R8 write while busy
        finish_job(25);
        chk("R8", "busy after completion", int'(busy), 1);
        push(200, 210, 105, 5, 6);
        chk("R8", "err on busy write", int'(err), 1);
        settle();
        chk("R6", "head start shifted", int'(head_start), 26);
        chk("R6", "head finish shifted", int'(head_finish), 35);
        chk("R7", "tail untouched by slack", int'(tail_finish), 70);

        // R5 early finish, no change
        finish_job(30);
        settle();
        chk("R7", "second entry shifted", int'(head_start), 36);
        chk("R5", "finish unchanged", int'(head_finish), 45);

        // R6 overrun onto last entry
        finish_job(62);
        settle();
        chk("R6", "last entry shifted start", int'(head_start), 63);
        chk("R6", "last entry tail", int'(tail_finish), 73);

        // R4 pop to empty, completion on empty ignored
        finish_job(80);
        chk("R4", "empty after pop", int'(empty), 1);
        chk("R4", "no busy on empty", int'(busy), 0);
        finish_job(90);
        chk("R4", "empty done ignored", int'(count), 0);

        // R9 write with completion refused
        push(5, 8, 110, 6, 7);
        wr_en = 1; done_en = 1; done_time = 9;
        wr_start = 50; wr_finish = 60;
        @(negedge clk);
        wr_en = 0; done_en = 0;
        chk("R9", "err on same cycle", int'(err), 1);
        chk("R9", "write dropped", int'(empty), 1);
        @(negedge clk);
        chk("R10", "err one cycle", int'(err), 0);

        // R7 ripple through to tail
        push(0, 10, 120, 7, 8);
        push(10, 20, 121, 7, 9);
        push(20, 30, 122, 7, 10);
        push(30, 40, 123, 7, 11);
        finish_job(15);
        settle();
        chk("R7", "ripple head", int'(head_start), 16);
        chk("R7", "ripple reached tail", int'(tail_finish), 48);
        finish_job(16);
        settle();
        chk("R5", "equal-before no shift", int'(head_start), 27);
        // R6 boundary: actual equals start gives shift of one
        finish_job(38);
        settle();
        chk("R6", "equal start shift 1", int'(head_start), 39);
        chk("R6", "equal start tail", int'(tail_finish), 49);
        finish_job(49);
        settle();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule